// File: doc/BRIEF.md
# E1 Frame Aligner

This block watches a serial E1 bit stream, one bit per strobe, and finds where each 256-bit frame begins. It locks onto the seven-bit alignment word that appears in the first timeslot of every other frame. In the frames between, it checks the second bit of that timeslot, which must be one. Until it holds alignment it reports loss of frame alignment. It then hunts for a candidate word at every bit position. It accepts a candidate only after a three-frame confirmation. Once aligned, it gives the bit position within the frame, so that later stages can pick out timeslots.

While aligned, it checks only the expected timeslot-0 positions. It counts consecutive bad alignment words and consecutive bad service words in two separate counters. When either counter reaches a configured limit of three or four, it drops back to hunting on its own. Each such loss raises a one-cycle interrupt pulse. Each successful regain raises a one-cycle found pulse.

Top module: `e1fa_aligner`

## Requirements
- R1: After reset, `lfa` is 1, `bit_pos` is 255, and `fas_found` and `lfa_irq` are 0. An asynchronous reset forces `lfa` to 1 at once.
- R2: While hunting, every valid bit is tested as the last bit of a candidate. A candidate exists when the last seven received bits, oldest first, read 0011011. On that bit `bit_pos` becomes 7, whatever its previous value.
- R3: The aligner regains alignment after three checks: a candidate in frame n, a service word in frame n+1 whose second timeslot-0 bit (bit_pos 1) is 1, and the alignment word again at bit_pos 1..7 of frame n+2. `lfa` clears and `fas_found` pulses for one cycle after the last bit of that second word is clocked in, with `bit_pos` equal to 7.
- R4: If the service check or the second alignment check fails, the candidate is dropped. `lfa` stays 1, and hunting resumes with the next valid bit, so a complete new three-frame sequence is needed.
- R5: While aligned, the alignment word is checked only at bit_pos 7 of alternate frames. A run of 3 consecutive bad words (`loss_cnt4`=0) or 4 (`loss_cnt4`=1) sets `lfa`. A correct word resets the run.
- R6: With `svc_chk_en`=1, a run of service words whose bit at bit_pos 1 is 0 sets `lfa` under the same 3/4 rule. With `svc_chk_en`=0, service-word errors have no effect on `lfa`.
- R7: `lfa_irq` pulses for exactly one cycle on every 0-to-1 transition of `lfa`, and at no other time. A reset does not raise it.
- R8: A cycle with `bit_vld`=0 changes nothing: `bit_pos` holds. While aligned, `bit_pos` advances by one per valid bit, wrapping from 255 to 0.
- R9: Alignment-word and service-word error runs are counted separately. A correct alignment word does not reset the service-word run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new line bit |
| bit_in | input | 1 | Received line bit |
| loss_cnt4 | input | 1 | 0: loss after 3 consecutive errors, 1: after 4 |
| svc_chk_en | input | 1 | Enables loss on service-word errors |
| lfa | output | 1 | Loss of frame alignment status |
| bit_pos | output | 8 | Position in frame of the last valid bit |
| fas_found | output | 1 | One-cycle pulse when alignment is regained |
| lfa_irq | output | 1 | One-cycle pulse on rising `lfa` |

## Verification
The bench drives sequences in which good error runs are broken one short of the limit. A design that forgot to reset its run, or shared one counter across both word types, would declare loss too early. Candidates are killed at the service step and at the second alignment step. A design that skipped a step, or kept the dead candidate, would clear `lfa` early. The limit is switched between three and four. Service checking is switched off while bad service words keep arriving, which exposes a design that ignores either setting. A hunt started off the reset phase shows whether `bit_pos` really snaps to 7 on a candidate. Idle strobe gaps and a reset during alignment catch a counter that drifts or an interrupt raised by reset.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_VFY_SW  = 2'd1,
    ST_VFY_FAS = 2'd2,
    ST_LOCK    = 2'd3
  } fa_state_e;

  // Alignment word, first-received bit is the MSB
  localparam logic [6:0] FAS_WORD = 7'b0011011;
  localparam int         FAS_LEN  = $bits(FAS_WORD);

endpackage

// File: rtl/e1fa_window.sv
module e1fa_window
  import e1fa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic fas_hit,
  output logic svc_hit
);

  localparam int WIN_W = FAS_LEN - 1;

  logic [WIN_W-1:0]   win_q;
  logic [WIN_W-1:0]   win_d;
  logic [FAS_LEN-1:0] win_n;

  // window including the bit currently offered
  always_comb begin
    win_n   = {win_q, bit_in};
    fas_hit = (win_n == FAS_WORD);
    svc_hit = win_n[FAS_LEN-1];
  end

  always_comb begin
    win_d = win_q;
    if (bit_vld) begin
      win_d = win_n[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '1;
    end else begin
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/e1fa_poscnt.sv
module e1fa_poscnt #(
  parameter int FRAME_BITS = 256,
  parameter int TS_BITS    = 8,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             realign,
  output logic [POS_W-1:0] pos,
  output logic             ts0_end
);

  localparam logic [POS_W-1:0] LAST     = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TS0_LAST = POS_W'(TS_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] idx;

  // index the incoming bit would take
  always_comb begin
    idx     = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    ts0_end = (idx == TS0_LAST);
  end

  always_comb begin
    pos_d = pos_q;
    if (bit_vld) begin
      pos_d = realign ? TS0_LAST : idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= LAST;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/e1fa_errcnt.sv
module e1fa_errcnt #(
  parameter int ERR_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic good,
  input  logic lim4,
  output logic lost
);

  localparam logic [ERR_W-1:0] PRE3 = ERR_W'(2);
  localparam logic [ERR_W-1:0] PRE4 = ERR_W'(3);
  localparam logic [ERR_W-1:0] CMAX = '1;

  logic [ERR_W-1:0] cnt_q;
  logic [ERR_W-1:0] cnt_d;

  // loss when this miss completes the configured run
  always_comb begin
    lost = step && !good && (cnt_q == (lim4 ? PRE4 : PRE3));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      if (good) begin
        cnt_d = '0;
      end else if (cnt_q != CMAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic ts0_end,
  input  logic fas_hit,
  input  logic svc_hit,
  input  logic fas_lost,
  input  logic svc_lost,
  input  logic svc_chk_en,
  output logic realign,
  output logic lock,
  output logic fas_step,
  output logic svc_step,
  output logic found_p,
  output logic loss_p
);

  fa_state_e state_q;
  fa_state_e state_d;
  logic      phase_q;  // 1: next check falls in an alignment-word frame
  logic      phase_d;
  logic      found_q;
  logic      found_d;
  logic      loss_q;
  logic      loss_d;
  logic      chk;

  always_comb begin
    chk      = bit_vld && ts0_end;
    realign  = (state_q == ST_HUNT) && bit_vld && fas_hit;
    fas_step = (state_q == ST_LOCK) && chk && phase_q;
    svc_step = (state_q == ST_LOCK) && chk && !phase_q && svc_chk_en;
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    found_d = 1'b0;
    loss_d  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (realign) begin
          state_d = ST_VFY_SW;
        end
      end
      ST_VFY_SW: begin
        if (chk) begin
          state_d = svc_hit ? ST_VFY_FAS : ST_HUNT;
        end
      end
      ST_VFY_FAS: begin
        if (chk) begin
          if (fas_hit) begin
            state_d = ST_LOCK;
            phase_d = 1'b0;
            found_d = 1'b1;
          end else begin
            state_d = ST_HUNT;
          end
        end
      end
      ST_LOCK: begin
        if (chk) begin
          phase_d = ~phase_q;
          if (fas_lost || svc_lost) begin
            state_d = ST_HUNT;
            loss_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      phase_q <= 1'b0;
      found_q <= 1'b0;
      loss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      found_q <= found_d;
      loss_q  <= loss_d;
    end
  end

  assign lock    = (state_q == ST_LOCK);
  assign found_p = found_q;
  assign loss_p  = loss_q;

endmodule

// File: rtl/e1fa_aligner.sv
module e1fa_aligner #(
  parameter int FRAME_BITS = 256,
  parameter int TS_BITS    = 8,
  parameter int ERR_W      = 3,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             loss_cnt4,
  input  logic             svc_chk_en,
  output logic             lfa,
  output logic [POS_W-1:0] bit_pos,
  output logic             fas_found,
  output logic             lfa_irq
);

  localparam int NUM_RUN = 2;  // 0: alignment word, 1: service word

  logic [1:0] rs_q;
  logic       srst_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign srst_n = rs_q[1];

  logic fas_hit;
  logic svc_hit;
  logic realign;
  logic ts0_end;
  logic lock;
  logic fas_step;
  logic svc_step;

  logic [NUM_RUN-1:0] run_clr;
  logic [NUM_RUN-1:0] run_step;
  logic [NUM_RUN-1:0] run_good;
  logic [NUM_RUN-1:0] run_lost;

  e1fa_window u_win (
    .clk     (clk),
    .rst_n   (srst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .fas_hit (fas_hit),
    .svc_hit (svc_hit)
  );

  e1fa_poscnt #(
    .FRAME_BITS (FRAME_BITS),
    .TS_BITS    (TS_BITS),
    .POS_W      (POS_W)
  ) u_pos (
    .clk     (clk),
    .rst_n   (srst_n),
    .bit_vld (bit_vld),
    .realign (realign),
    .pos     (bit_pos),
    .ts0_end (ts0_end)
  );

  always_comb begin
    run_clr[0]  = ~lock;
    run_step[0] = fas_step;
    run_good[0] = fas_hit;
    run_clr[1]  = ~lock | ~svc_chk_en;
    run_step[1] = svc_step;
    run_good[1] = svc_hit;
  end

  generate
    for (genvar k = 0; k < NUM_RUN; k++) begin : g_run
      e1fa_errcnt #(
        .ERR_W (ERR_W)
      ) u_cnt (
        .clk   (clk),
        .rst_n (srst_n),
        .clr   (run_clr[k]),
        .step  (run_step[k]),
        .good  (run_good[k]),
        .lim4  (loss_cnt4),
        .lost  (run_lost[k])
      );
    end
  endgenerate

  e1fa_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .bit_vld    (bit_vld),
    .ts0_end    (ts0_end),
    .fas_hit    (fas_hit),
    .svc_hit    (svc_hit),
    .fas_lost   (run_lost[0]),
    .svc_lost   (run_lost[1]),
    .svc_chk_en (svc_chk_en),
    .realign    (realign),
    .lock       (lock),
    .fas_step   (fas_step),
    .svc_step   (svc_step),
    .found_p    (fas_found),
    .loss_p     (lfa_irq)
  );

  assign lfa = ~lock;

endmodule

// File: rtl/e1fa_aligner_chk.sv
module e1fa_aligner_chk #(
  parameter int FRAME_BITS = 256,
  parameter int TS_BITS    = 8,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             lfa,
  input logic [POS_W-1:0] bit_pos,
  input logic             fas_found,
  input logic             lfa_irq
);

  localparam logic [POS_W-1:0] LAST     = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TS0_LAST = POS_W'(TS_BITS - 1);

  // R7
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lfa) |-> lfa_irq);

  // R7
  irq_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfa_irq |-> (lfa && !$past(lfa)));

  // R3
  found_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fas_found |-> $fell(lfa));

  // R3
  fall_gives_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lfa) |-> fas_found);

  // R3
  found_at_ts0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fas_found |-> (bit_pos == TS0_LAST));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(bit_pos));

  // R8
  lock_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lfa && bit_vld) |=>
      (bit_pos == (($past(bit_pos) == LAST) ? '0 : $past(bit_pos) + 1'b1)));

endmodule

bind e1fa_aligner e1fa_aligner_chk #(
  .FRAME_BITS (FRAME_BITS),
  .TS_BITS    (TS_BITS),
  .POS_W      (POS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .lfa       (lfa),
  .bit_pos   (bit_pos),
  .fas_found (fas_found),
  .lfa_irq   (lfa_irq)
);

// File: tb/e1fa_aligner_tb.sv
module e1fa_aligner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NFR        = 53;

  // per frame: {word_ok, loss_cnt4, svc_chk_en, exp_lfa, exp_found, exp_irq}
  // even frames carry the alignment word, odd frames the service word
  localparam logic [5:0] VEC [NFR] = '{
    6'b101100, 6'b101100, 6'b101010, 6'b101000, 6'b001000, 6'b101000,
    6'b001000, 6'b101000, 6'b101000, 6'b101000, 6'b001000, 6'b101000,
    6'b001000, 6'b101000, 6'b001101, 6'b101100, 6'b101100, 6'b101100,
    6'b101010, 6'b001000, 6'b101000, 6'b001000, 6'b101000, 6'b001101,
    6'b101100, 6'b001100, 6'b101100, 6'b101100, 6'b001100, 6'b101100,
    6'b101100, 6'b101100, 6'b101010, 6'b111000, 6'b011000, 6'b111000,
    6'b011000, 6'b111000, 6'b011000, 6'b111000, 6'b011101, 6'b111100,
    6'b111100, 6'b111100, 6'b111010, 6'b010000, 6'b110000, 6'b010000,
    6'b110000, 6'b010000, 6'b110000, 6'b010000, 6'b110000
  };

  logic       clk;
  logic       rst_n;
  logic       bit_vld;
  logic       bit_in;
  logic       loss_cnt4;
  logic       svc_chk_en;
  logic       lfa;
  logic [7:0] bit_pos;
  logic       fas_found;
  logic       lfa_irq;

  int n_chk;
  int n_err;

  e1fa_aligner dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .loss_cnt4  (loss_cnt4),
    .svc_chk_en (svc_chk_en),
    .lfa        (lfa),
    .bit_pos    (bit_pos),
    .fas_found  (fas_found),
    .lfa_irq    (lfa_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // timeslot-0 contents: alignment frame good/bad, service frame good/bad
  function automatic logic [7:0] ts0_word(input int f, input logic ok);
    if (f % 2 == 0) return ok ? 8'b10011011 : 8'b10011010;
    return ok ? 8'b11011111 : 8'b10011111;
  endfunction

  function automatic string lfa_tag(input int f);
    if (f <= 2)  return "R3";
    if (f >= 19 && f <= 23) return "R9";
    if (f >= 24 && f <= 32) return "R4";
    if (f >= 45) return "R6";
    return "R5";
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    bit_vld = 1'b0;
    #1;
    // R1: asynchronous assertion forces loss state at once
    chk("R1 lfa async", lfa, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    n_chk      = 0;
    n_err      = 0;
    rst_n      = 1'b0;
    bit_vld    = 1'b0;
    bit_in     = 1'b1;
    loss_cnt4  = 1'b0;
    svc_chk_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    chk("R1 lfa", lfa, 1);
    chk("R1 bit_pos", bit_pos, 255);
    chk("R1 fas_found", fas_found, 0);
    chk("R1 lfa_irq", lfa_irq, 0);

    // table walk, frame by frame
    for (int f = 0; f < NFR; f++) begin
      logic [7:0] w;
      loss_cnt4  = VEC[f][4];
      svc_chk_en = VEC[f][3];
      w = ts0_word(f, VEC[f][5]);
      for (int i = 0; i < 256; i++) begin
        send_bit((i < 8) ? w[7-i] : 1'b1);
        if (i == 7) begin
          chk(lfa_tag(f), lfa, VEC[f][2]);
          chk("R3 found", fas_found, VEC[f][1]);
          chk("R7 irq", lfa_irq, VEC[f][0]);
          chk("R2 bit_pos", bit_pos, 7);
        end
        if (i == 8) begin
          chk("R7 irq width", lfa_irq, 0);
          chk("R3 found width", fas_found, 0);
          idle(3);
          // R8 no advance without strobe
          chk("R8 hold", bit_pos, 8);
          chk("R8 lfa hold", lfa, VEC[f][2]);
        end
      end
    end

    // R2: candidate off the reset phase snaps bit_pos to 7
    loss_cnt4  = 1'b0;
    svc_chk_en = 1'b1;
    do_reset();
    chk("R7 no irq on reset", lfa_irq, 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(ts0_word(0, 1'b1)[7-i]);
    chk("R2 realign pos", bit_pos, 7);
    chk("R2 still lfa", lfa, 1);
    for (int i = 8; i < 256; i++) send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(ts0_word(1, 1'b1)[7-i]);
    chk("R3 mid lfa", lfa, 1);
    for (int i = 8; i < 256; i++) send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(ts0_word(0, 1'b1)[7-i]);
    chk("R3 shifted lfa", lfa, 0);
    chk("R3 shifted found", fas_found, 1);
    chk("R3 shifted pos", bit_pos, 7);
    for (int i = 8; i < 40; i++) send_bit(1'b1);
    // R8 wrap-free advance while aligned
    chk("R8 advance", bit_pos, 39);

    // R7: reset while aligned raises lfa but no interrupt
    do_reset();
    chk("R7 reset irq", lfa_irq, 0);
    chk("R1 lfa after reset", lfa, 1);
    chk("R1 pos after reset", bit_pos, 255);

    report();
    $finish;
  end

endmodule